// File: doc/BRIEF.md
# Lane-Partitioned Accumulator Store with Column Allocator

This block is an on-chip accumulator store arranged as lanes (rows) by columns of 32-bit cells. By default it has 128 lanes and 512 columns, 256 KB in all. The lanes are split into four fixed quarters. Each quarter has one requester port, and that port can only touch its own quarter. Covering every lane therefore takes all four requesters working together. Each port carries a valid, a write-enable, a column address and a 32-lane data vector. Every access returns the prior contents of the addressed cell one cycle later.

Columns cannot be used until they have been claimed. A command channel with a valid/ready handshake accepts allocate and free commands. Each accepted command yields exactly one registered response, also held under valid/ready. Allocation sizes are powers of two of at least one 32-column granule. The allocator keeps a one-bit-per-granule occupancy map and searches it first-fit. It returns either the base column or a failure flag.

Misuse raises a sticky error flag that only reset clears. Freeing space that is not held is misuse, and so is accessing a column that is not allocated. Misuse never alters stored data.

Top module: `accum_store`

## Requirements
- R1: After reset `err_o`, `rsp_valid_o` and `acc_rvalid_o` are 0, `cmd_ready_o` is 1, and every granule is free.
- R2: An accepted command (`cmd_valid_i` and `cmd_ready_o` high at an edge) produces `rsp_valid_o` after that edge. Allocate size code k (`cmd_free_i`=0) asks for 32·2^k columns, with k from 0 to 4. A successful response has `rsp_fail_o`=0 and a `rsp_base_o` that is a multiple of 32.
- R3: Allocation is first-fit. The base is the lowest granule index whose 2^k consecutive granules are all free.
- R4: An allocate command fails (`rsp_fail_o`=1, `rsp_base_o`=0) when the size code exceeds 4 or no free run exists. The occupancy map and `err_o` stay unchanged.
- R5: A free command (`cmd_free_i`=1) takes `cmd_base_i` and size code k, and `rsp_base_o` echoes the base. The command succeeds only if the base is a multiple of 32, the range lies inside the array, and every granule in it is allocated. Otherwise `rsp_fail_o`=1, `err_o` is set, and the map is unchanged.
- R6: While `rsp_valid_o`=1 and `rsp_ready_i`=0, `cmd_ready_o` is 0 and the response stays stable.
- R7: On port g, bits [32j+31:32j] of the data vector are lane 32·g+j. An access through one port never changes data seen through another port.
- R8: `acc_rvalid_o[g]` and `acc_rdata_o` follow a request by one cycle. The read data is the cell content before the access, so a write returns the old value.
- R9: An access to a column whose granule is not allocated writes nothing, returns zero data and sets `err_o`.
- R10: Once set, `err_o` stays 1 until reset. Data written before a free survives the free and a later re-allocation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid_i | input | 1 | Command valid |
| cmd_ready_o | output | 1 | Command accepted when high |
| cmd_free_i | input | 1 | 1 = free, 0 = allocate |
| cmd_size_i | input | 3 | Size code k: 32·2^k columns |
| cmd_base_i | input | 9 | Base column for a free |
| rsp_valid_o | output | 1 | Response valid |
| rsp_ready_i | input | 1 | Response consumed when high |
| rsp_fail_o | output | 1 | Command failed |
| rsp_base_o | output | 9 | Allocated base, or echoed free base |
| acc_req_i | input | 4 | Per-port access request |
| acc_we_i | input | 4 | Per-port write enable |
| acc_col_i | input | 36 | Per-port column address, 9 bits each |
| acc_wdata_i | input | 4096 | Per-port write vector, 1024 bits each |
| acc_rvalid_o | output | 4 | Per-port read valid |
| acc_rdata_o | output | 4096 | Per-port read vector, 1024 bits each |
| err_o | output | 1 | Sticky misuse flag |

## Verification
A corrupted occupancy map shows up on the next allocate response as a wrong base or a wrong failure. It also shows up on the next access to an affected column as zero read data together with a raised error flag, one cycle after the request. Crossed lane wiring or a wrong bank select appears one cycle after a read through a neighbouring port that should have been untouched. A misplaced read-before-write shows as new data where old data is expected on the write's own response.

// File: rtl/accum_store.sv
module accum_store #(
  parameter int LANES     = 128,
  parameter int COLS      = 512,
  parameter int GROUPS    = 4,
  parameter int GRAN_COLS = 32,
  parameter int CELL_W    = 32,
  localparam int CW    = $clog2(COLS),
  localparam int NGRAN = COLS / GRAN_COLS,
  localparam int GL    = $clog2(NGRAN),
  localparam int SW    = $clog2(GL + 1),
  localparam int GCL   = $clog2(GRAN_COLS),
  localparam int PW    = (LANES / GROUPS) * CELL_W
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cmd_valid_i,
  output logic                 cmd_ready_o,
  input  logic                 cmd_free_i,
  input  logic [SW-1:0]        cmd_size_i,
  input  logic [CW-1:0]        cmd_base_i,
  output logic                 rsp_valid_o,
  input  logic                 rsp_ready_i,
  output logic                 rsp_fail_o,
  output logic [CW-1:0]        rsp_base_o,
  input  logic [GROUPS-1:0]    acc_req_i,
  input  logic [GROUPS-1:0]    acc_we_i,
  input  logic [GROUPS*CW-1:0] acc_col_i,
  input  logic [GROUPS*PW-1:0] acc_wdata_i,
  output logic [GROUPS-1:0]    acc_rvalid_o,
  output logic [GROUPS*PW-1:0] acc_rdata_o,
  output logic                 err_o
);

  logic [NGRAN-1:0]   used;
  logic [2*NGRAN-1:0] run, occ, fmask, amask;
  logic [GL-1:0]      fit_gran;
  logic               fit_ok, free_ok, alloc_ok, size_ok, take;
  logic [GROUPS-1:0]  bad_acc;

  assign size_ok     = cmd_size_i <= SW'(GL);
  assign run         = ((2*NGRAN)'(1) << (32'd1 << cmd_size_i)) - (2*NGRAN)'(1);
  assign occ         = {{NGRAN{1'b1}}, used};
  assign cmd_ready_o = !rsp_valid_o || rsp_ready_i;
  assign take        = cmd_valid_i && cmd_ready_o;

  always_comb begin
    fit_ok   = 1'b0;
    fit_gran = '0;
    for (int s = 0; s < NGRAN; s++)
      if (!fit_ok && (((run << s) & occ) == '0)) begin
        fit_ok   = 1'b1;
        fit_gran = GL'(s);
      end
  end

  assign alloc_ok = size_ok && fit_ok;
  assign amask    = run << fit_gran;
  assign fmask    = run << cmd_base_i[CW-1:GCL];
  assign free_ok  = size_ok && (cmd_base_i[GCL-1:0] == '0) &&
                    ((fmask & {{NGRAN{1'b0}}, used}) == fmask);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      used        <= '0;
      rsp_valid_o <= 1'b0;
      rsp_fail_o  <= 1'b0;
      rsp_base_o  <= '0;
    end else if (take) begin
      rsp_valid_o <= 1'b1;
      if (cmd_free_i) begin
        rsp_fail_o <= !free_ok;
        rsp_base_o <= cmd_base_i;
        if (free_ok) used <= used & ~fmask[NGRAN-1:0];
      end else begin
        rsp_fail_o <= !alloc_ok;
        rsp_base_o <= alloc_ok ? {fit_gran, {GCL{1'b0}}} : '0;
        if (alloc_ok) used <= used | amask[NGRAN-1:0];
      end
    end else if (rsp_ready_i) begin
      rsp_valid_o <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) err_o <= 1'b0;
    else if ((take && cmd_free_i && !free_ok) || (|bad_acc)) err_o <= 1'b1;
  end

  for (genvar g = 0; g < GROUPS; g++) begin : grp
    logic [PW-1:0] mem [COLS];
    logic [PW-1:0] rd_q;
    logic [CW-1:0] col;
    logic          hit;

    assign col        = acc_col_i[g*CW +: CW];
    assign hit        = used[col[CW-1:GCL]];
    assign bad_acc[g] = acc_req_i[g] && !hit;

    always_ff @(posedge clk)
      if (acc_req_i[g] && acc_we_i[g] && hit) mem[col] <= acc_wdata_i[g*PW +: PW];

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        acc_rvalid_o[g] <= 1'b0;
        rd_q            <= '0;
      end else begin
        acc_rvalid_o[g] <= acc_req_i[g];
        if (acc_req_i[g]) rd_q <= hit ? mem[col] : '0;
      end
    end

    assign acc_rdata_o[g*PW +: PW] = rd_q;
  end

endmodule

// File: rtl/accum_store_chk.sv
module accum_store_chk #(
  parameter int CW     = 9,
  parameter int SW     = 3,
  parameter int GCL    = 5,
  parameter int GROUPS = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cmd_valid_i,
  input logic              cmd_ready_o,
  input logic              cmd_free_i,
  input logic [CW-1:0]     cmd_base_i,
  input logic              rsp_valid_o,
  input logic              rsp_ready_i,
  input logic              rsp_fail_o,
  input logic [CW-1:0]     rsp_base_o,
  input logic [GROUPS-1:0] acc_req_i,
  input logic [GROUPS-1:0] acc_rvalid_o,
  input logic              err_o
);

  // R10
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |=> err_o);

  // R6
  rsp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid_o && !rsp_ready_i |=> rsp_valid_o && $stable(rsp_base_o) && $stable(rsp_fail_o));

  // R2
  rsp_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid_i && cmd_ready_o |=> rsp_valid_o);

  // R2
  rsp_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid_o && !rsp_fail_o |-> rsp_base_o[GCL-1:0] == '0);

  // R8
  rvalid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|acc_req_i) |=> acc_rvalid_o == $past(acc_req_i));

  // R5
  bad_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid_i && cmd_ready_o && cmd_free_i && cmd_base_i[GCL-1:0] != '0 |=> err_o && rsp_fail_o);

endmodule

bind accum_store accum_store_chk #(.CW(CW), .SW(SW), .GCL(GCL), .GROUPS(GROUPS)) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_valid_i(cmd_valid_i), .cmd_ready_o(cmd_ready_o),
  .cmd_free_i(cmd_free_i), .cmd_base_i(cmd_base_i), .rsp_valid_o(rsp_valid_o),
  .rsp_ready_i(rsp_ready_i), .rsp_fail_o(rsp_fail_o), .rsp_base_o(rsp_base_o),
  .acc_req_i(acc_req_i), .acc_rvalid_o(acc_rvalid_o), .err_o(err_o));

// File: tb/accum_store_test.sv
module accum_store_test;
  localparam int G = 4, CW = 9, SW = 3, PW = 1024;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cmd_valid_i = 0, cmd_free_i = 0, rsp_ready_i = 1;
  logic [SW-1:0] cmd_size_i = '0;
  logic [CW-1:0] cmd_base_i = '0;
  logic cmd_ready_o, rsp_valid_o, rsp_fail_o, err_o;
  logic [CW-1:0] rsp_base_o;
  logic [G-1:0] acc_req_i = '0, acc_we_i = '0, acc_rvalid_o;
  logic [G*CW-1:0] acc_col_i = '0;
  logic [G*PW-1:0] acc_wdata_i = '0, acc_rdata_o;

  int tests = 0, fails = 0;
  bit done = 0;

  accum_store uut (.*);

  always #2 clk = ~clk;

  // row: free, size, base, exp_fail, exp_base, exp_err
  localparam logic [23:0] TBL [18] = '{
    {1'b0, 3'd0, 9'd0,   1'b0, 9'd0,   1'b0},
    {1'b0, 3'd1, 9'd0,   1'b0, 9'd32,  1'b0},
    {1'b0, 3'd2, 9'd0,   1'b0, 9'd96,  1'b0},
    {1'b1, 3'd1, 9'd32,  1'b0, 9'd32,  1'b0},
    {1'b0, 3'd0, 9'd0,   1'b0, 9'd32,  1'b0},
    {1'b0, 3'd1, 9'd0,   1'b0, 9'd224, 1'b0},
    {1'b0, 3'd4, 9'd0,   1'b1, 9'd0,   1'b0},
    {1'b0, 3'd3, 9'd0,   1'b1, 9'd0,   1'b0},
    {1'b0, 3'd2, 9'd0,   1'b0, 9'd288, 1'b0},
    {1'b0, 3'd5, 9'd0,   1'b1, 9'd0,   1'b0},
    {1'b1, 3'd0, 9'd64,  1'b1, 9'd64,  1'b1},
    {1'b1, 3'd2, 9'd96,  1'b0, 9'd96,  1'b1},
    {1'b0, 3'd3, 9'd0,   1'b1, 9'd0,   1'b1},
    {1'b0, 3'd2, 9'd0,   1'b0, 9'd64,  1'b1},
    {1'b1, 3'd0, 9'd33,  1'b1, 9'd33,  1'b1},
    {1'b1, 3'd1, 9'd480, 1'b1, 9'd480, 1'b1},
    {1'b0, 3'd0, 9'd0,   1'b0, 9'd192, 1'b1},
    {1'b0, 3'd0, 9'd0,   1'b0, 9'd416, 1'b1}
  };

  function automatic logic [PW-1:0] pat(int g, int col, int seed);
    logic [PW-1:0] p;
    for (int j = 0; j < 32; j++)
      p[j*32 +: 32] = {seed[7:0], g[3:0], j[4:0], 3'b0, col[11:0]};
    return p;
  endfunction

  task automatic check(string tag, logic [PW-1:0] act, logic [PW-1:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cmd(bit fr, int sz, int base, output bit fail, output int rb);
    @(negedge clk);
    cmd_valid_i = 1; cmd_free_i = fr; cmd_size_i = sz[SW-1:0]; cmd_base_i = base[CW-1:0];
    @(posedge clk); #1;
    fail = rsp_fail_o; rb = int'(rsp_base_o);
    @(negedge clk);
    cmd_valid_i = 0;
  endtask

  task automatic access(int g, bit we, int col, logic [PW-1:0] wd,
                        output logic [PW-1:0] rd, output bit rv);
    @(negedge clk);
    acc_req_i[g] = 1; acc_we_i[g] = we;
    acc_col_i[g*CW +: CW] = col[CW-1:0]; acc_wdata_i[g*PW +: PW] = wd;
    @(posedge clk); #1;
    rd = acc_rdata_o[g*PW +: PW]; rv = acc_rvalid_o[g];
    @(negedge clk);
    acc_req_i[g] = 0; acc_we_i[g] = 0;
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    bit f, rv;
    int b;
    logic [PW-1:0] rd;

    repeat (3) @(negedge clk);
    rst_n = 1;
    #1;
    check("R1 err", PW'(err_o), 0);
    check("R1 rsp_valid", PW'(rsp_valid_o), 0);
    check("R1 cmd_ready", PW'(cmd_ready_o), 1);
    check("R1 rvalid", PW'(acc_rvalid_o), 0);

    cmd(0, 2, 0, f, b);
    check("R2 alloc fail", PW'(f), 0);
    check("R2 alloc base", PW'(b), 0);

    for (int g = 0; g < G; g++) access(g, 1, 5, pat(g, 5, 1), rd, rv);
    check("R8 rvalid", PW'(rv), 1);
    for (int g = 0; g < G; g++) begin
      access(g, 0, 5, '0, rd, rv);
      check($sformatf("R7 lane group %0d", g), rd, pat(g, 5, 1));
    end
    access(0, 1, 5, pat(0, 5, 2), rd, rv);
    check("R8 write returns old", rd, pat(0, 5, 1));
    access(1, 0, 5, '0, rd, rv);
    check("R7 neighbour untouched", rd, pat(1, 5, 1));
    access(0, 0, 5, '0, rd, rv);
    check("R8 new value", rd, pat(0, 5, 2));
    check("R9 no error yet", PW'(err_o), 0);

    cmd(0, 2, 0, f, b);
    check("R3 second alloc base", PW'(b), 128);
    access(2, 1, 200, pat(2, 200, 3), rd, rv);
    cmd(1, 2, 128, f, b);
    check("R5 free ok", PW'(f), 0);
    check("R5 free no err", PW'(err_o), 0);
    access(2, 1, 200, pat(2, 200, 4), rd, rv);
    check("R9 unallocated read zero", rd, '0);
    check("R9 err set", PW'(err_o), 1);
    cmd(0, 2, 0, f, b);
    check("R3 realloc base", PW'(b), 128);
    access(2, 0, 200, '0, rd, rv);
    check("R10 data kept, R9 no write", rd, pat(2, 200, 3));
    check("R10 err sticky", PW'(err_o), 1);

    do_reset();
    #1;
    check("R1 err cleared by reset", PW'(err_o), 0);
    for (int i = 0; i < 18; i++) begin
      logic [23:0] r;
      string t;
      r = TBL[i];
      cmd(r[23], int'(r[22:20]), int'(r[19:11]), f, b);
      t = r[23] ? "R5" : (r[10] ? "R4" : "R3");
      check($sformatf("%s row %0d fail", t, i), PW'(f), PW'(r[10]));
      check($sformatf("%s row %0d base", t, i), PW'(b), PW'(r[9:1]));
      check($sformatf("%s row %0d err", t, i), PW'(err_o), PW'(r[0]));
    end

    @(negedge clk);
    rsp_ready_i = 0;
    cmd_valid_i = 1; cmd_free_i = 0; cmd_size_i = 0;
    @(posedge clk); #1;
    check("R6 first rsp", PW'(rsp_base_o), 448);
    check("R6 ready low", PW'(cmd_ready_o), 0);
    @(posedge clk); #1;
    check("R6 held base", PW'(rsp_base_o), 448);
    check("R6 still valid", PW'(rsp_valid_o), 1);
    @(negedge clk);
    rsp_ready_i = 1;
    @(posedge clk); #1;
    check("R6 next rsp", PW'(rsp_base_o), 480);
    @(negedge clk);
    cmd_valid_i = 0;
    @(posedge clk); #1;
    check("R6 drained", PW'(rsp_valid_o), 0);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule